// File: doc/BRIEF.md
# Wake-up power sequencer with trim register access

This block sits behind a wake-up pattern decoder. A one-cycle match pulse from the decoder, taken while the block is idle, turns on both the supply regulator enable and the clock oscillator enable. The block then waits for the host controller to raise its ready line. A cycle counter guards this wait. If ready does not arrive within `TIMEOUT_CYC` clock cycles, both enables fall, the block returns to idle, and a one-cycle timeout pulse is raised.

When ready rises, the oscillator enable drops and the regulator enable stays on. The block then serves a small bus into an eight-entry, eight-bit trim register file. Each strobe carries a direction flag, an address and write data, and performs exactly one access. When ready falls, the session ends: the regulator enable drops and the block is idle again. The trim values stay in place for the next session. An active-low power-on reset holds the block in idle and clears the trim file.

Top module: `wake_seq_trim`

## Requirements
- R1: While `por_n` is low, and on the first cycle after it is released, `vreg_en`, `osc_en`, `wdt_expired` and `rd_valid` are all 0.
- R2: A `wake_match` pulse sampled in idle sets both `vreg_en` and `osc_en` to 1 on the next cycle.
- R3: `host_ready` sampled high while waiting clears `osc_en` on the next cycle and keeps `vreg_en` at 1. A ready that arrives in the last cycle of the timeout window still wins over the timeout.
- R4: If `host_ready` stays low for `TIMEOUT_CYC` cycles after wake-up, both enables fall on the following cycle. `wdt_expired` is 1 for exactly that one cycle.
- R5: In a session (`host_ready` high after the wait), a strobe with `bus_rw`=0 stores `bus_wdata` at `bus_addr`.
- R6: In a session, a strobe with `bus_rw`=1 puts the entry at `bus_addr` on `rd_data`, with `rd_valid`=1 on the cycle after the strobe only.
- R7: Strobes that arrive in idle or while waiting for ready change no trim entry and raise no `rd_valid`.
- R8: `host_ready` sampled low during a session clears `vreg_en` on the next cycle, and a later `wake_match` starts a new wake-up.
- R9: A `wake_match` that arrives while not idle has no effect on the enables.
- R10: Trim entries keep their values from one session to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset |
| wake_match | input | 1 | Match pulse from the wake-up decoder |
| host_ready | input | 1 | Ready handshake from the host controller |
| bus_strobe | input | 1 | Starts one register access |
| bus_rw | input | 1 | 0 = write, 1 = read |
| bus_addr | input | 3 | Trim entry index |
| bus_wdata | input | 8 | Write data |
| vreg_en | output | 1 | Regulator enable |
| osc_en | output | 1 | Oscillator enable |
| wdt_expired | output | 1 | One-cycle timeout pulse |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Marks `rd_data` as valid |

## Verification
The hardest case to reach is the exact edge of the timeout window. Here ready arrives in the last counted cycle and must still win, while one cycle later the watchdog would already have fired. The stimulus counts clock cycles from the wake pulse, so ready is raised at precisely `TIMEOUT_CYC-1` cycles in one run and never in another. A second hard case is a strobe given in idle or while waiting. It leaves no trace at the outputs. The bench therefore reads the target entries back in a later session to show that the stored values did not change.

// File: rtl/wake_seq_trim.sv
module wake_seq_trim #(
  parameter int TIMEOUT_CYC = 16,
  parameter int DEPTH = 8,
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     wake_match,
  input  logic                     host_ready,
  input  logic                     bus_strobe,
  input  logic                     bus_rw,
  input  logic [$clog2(DEPTH)-1:0] bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic                     vreg_en,
  output logic                     osc_en,
  output logic                     wdt_expired,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_valid
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SESS} st_t;
  st_t st;
  logic [CW-1:0] wcnt;
  logic [DW-1:0] trim [DEPTH];

  wire in_sess = (st == S_SESS) && host_ready;
  wire do_wr   = in_sess && bus_strobe && !bus_rw;
  wire do_rd   = in_sess && bus_strobe && bus_rw;
  wire expire  = (st == S_WAIT) && !host_ready && (wcnt == CW'(TIMEOUT_CYC - 1));

  assign vreg_en = (st != S_IDLE);
  assign osc_en  = (st == S_WAIT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st          <= S_IDLE;
      wcnt        <= '0;
      wdt_expired <= 1'b0;
    end else begin
      wdt_expired <= expire;
      case (st)
        S_IDLE: begin
          wcnt <= '0;
          if (wake_match) st <= S_WAIT;
        end
        S_WAIT: begin
          if (host_ready) st <= S_SESS;
          else if (expire) st <= S_IDLE;
          else wcnt <= wcnt + 1'b1;
        end
        S_SESS: if (!host_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) trim[i] <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (do_wr) trim[bus_addr] <= bus_wdata;
      rd_valid <= do_rd;
      if (do_rd) rd_data <= trim[bus_addr];
    end
  end

  assert_wake_sets_enables_R2: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_IDLE && wake_match) |=> (vreg_en && osc_en));
  assert_ready_drops_osc_R3: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_WAIT && host_ready) |=> (!osc_en && vreg_en));
  assert_timeout_idle_R4: assert property (@(posedge clk) disable iff (!por_n)
    wdt_expired |-> (!vreg_en && !osc_en));
  assert_timeout_single_R4: assert property (@(posedge clk) disable iff (!por_n)
    wdt_expired |=> !wdt_expired);
  assert_read_follows_strobe_R6: assert property (@(posedge clk) disable iff (!por_n)
    rd_valid |-> $past(bus_strobe && bus_rw && host_ready));
  assert_ready_fall_idle_R8: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_SESS && !host_ready) |=> !vreg_en);
endmodule

// File: tb/wake_seq_trim_tb.sv
module wake_seq_trim_tb;
  localparam int TO = 16;
  logic clk = 0, por_n = 0, wake_match = 0, host_ready = 0;
  logic bus_strobe = 0, bus_rw = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic vreg_en, osc_en, wdt_expired, rd_valid;
  logic [7:0] rd_data;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  wake_seq_trim #(.TIMEOUT_CYC(TO), .DEPTH(8), .DW(8)) u_dut (
    .clk(clk), .por_n(por_n), .wake_match(wake_match), .host_ready(host_ready),
    .bus_strobe(bus_strobe), .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .vreg_en(vreg_en), .osc_en(osc_en), .wdt_expired(wdt_expired),
    .rd_data(rd_data), .rd_valid(rd_valid));

  localparam logic [10:0] VEC [8] = '{
    {3'd5, 8'h5A}, {3'd0, 8'hC3}, {3'd7, 8'h0F}, {3'd2, 8'hF0},
    {3'd4, 8'h81}, {3'd1, 8'h7E}, {3'd6, 8'h33}, {3'd3, 8'hA5}};

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
    bus_strobe = 1; bus_rw = 1; bus_addr = a; step();
    bus_strobe = 0;
    check(req, {rd_valid, rd_data}, {1'b1, exp});
  endtask

  task automatic wake_to_session();
    wake_match = 1; step(); wake_match = 0;
    host_ready = 1; step();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    @(negedge clk); step();
    check("R1 reset", {vreg_en, osc_en, wdt_expired, rd_valid}, 4'b0000);
    por_n = 1; step();
    check("R1 after release", {vreg_en, osc_en, wdt_expired, rd_valid}, 4'b0000);

    wake_match = 1; step(); wake_match = 0;
    check("R2 enables on match", {vreg_en, osc_en}, 2'b11);
    host_ready = 1; step();
    check("R3 ready drops osc", {vreg_en, osc_en}, 2'b10);

    for (int i = 0; i < 8; i++) begin
      bus_strobe = 1; bus_rw = 0; bus_addr = VEC[i][10:8]; bus_wdata = VEC[i][7:0];
      step();
    end
    bus_strobe = 0; step();
    check("R6 no valid without read", rd_valid, 0);
    for (int i = 7; i >= 0; i--) rd(VEC[i][10:8], VEC[i][7:0], "R5 R6 readback");
    step();
    check("R6 valid one cycle", rd_valid, 0);

    wake_match = 1; step(); wake_match = 0;
    check("R9 match in session ignored", {vreg_en, osc_en}, 2'b10);

    host_ready = 0; step();
    check("R8 ready fall idle", {vreg_en, osc_en}, 2'b00);

    bus_strobe = 1; bus_rw = 0; bus_addr = 3'd2; bus_wdata = 8'hFF; step();
    bus_rw = 1; step(); bus_strobe = 0;
    check("R7 idle read no valid", rd_valid, 0);
    wake_match = 1; step(); wake_match = 0;
    check("R8 rewake", {vreg_en, osc_en}, 2'b11);
    bus_strobe = 1; bus_rw = 0; bus_addr = 3'd3; bus_wdata = 8'hEE; step();
    bus_strobe = 0;
    host_ready = 1; step();
    rd(3'd2, 8'hF0, "R7 idle write ignored");
    rd(3'd3, 8'hA5, "R7 wait write ignored");
    rd(3'd5, 8'h5A, "R10 kept across sessions");
    host_ready = 0; step();

    wake_match = 1; step(); wake_match = 0;
    for (int i = 0; i < TO - 1; i++) step();
    check("R4 still waiting", {vreg_en, osc_en, wdt_expired}, 3'b110);
    step();
    check("R4 timeout", {vreg_en, osc_en, wdt_expired}, 3'b001);
    step();
    check("R4 pulse single", wdt_expired, 0);

    wake_match = 1; step(); wake_match = 0;
    for (int i = 0; i < TO - 1; i++) step();
    host_ready = 1; step();
    check("R3 ready at window edge", {vreg_en, osc_en, wdt_expired}, 3'b100);
    bus_strobe = 1; bus_rw = 0; bus_addr = 3'd1; bus_wdata = 8'h99; step();
    bus_strobe = 0;
    rd(3'd1, 8'h99, "R5 write after edge");
    host_ready = 0; step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule